// File: doc/BRIEF.md
# Sequential Floating-Point Adder

This block adds or subtracts two floating-point words, an accumulator and an operand, one small step per clock. Each word has a 7-bit exponent field with a bias of 64 and a 41-bit two's-complement mantissa (a sign bit plus 40 fraction bits). The result mantissa is 80 bits wide plus its sign. The sign and upper 40 bits return as the new accumulator mantissa, and the lower 40 bits go to an extension register.

The work runs in strict phases. First, exponent alignment shifts the mantissa with the smaller exponent right by one bit per cycle, copying the sign into the vacated bits. Next, the addition repeats a carry-reduction step until no carries remain. Then a one-step correction handles mantissa overflow. Last, when enabled, left normalization shifts by one bit per cycle. None of the phases exits early, so the latency depends on the data. It ranges from 5 cycles for an integer sum with nothing to carry up to 259 cycles when two zeros with extreme exponents are added.

Top module: `seq_fp_adder`

## Requirements
- R1: Opcode 2'b00 forms ACC+OP, 2'b01 forms ACC-OP, 2'b10 forms OP-ACC, and 2'b11 forms |ACC|-|OP|. Mantissa value = signed 41-bit field / 2^40. Exponent = field - 64. The result mantissa is {res_man, res_ext}: res_man[40] is the sign, and res_ext holds the 40 bits below res_man[0].
- R2: Alignment shifts the mantissa with the smaller exponent right by one bit per cycle, filling with its sign bit. Bits pass from the upper word into res_ext and are lost only below its bit 0. The shifting continues until the exponents are equal, even once that mantissa is all sign bits. The result exponent is the larger exponent.
- R3: The sum is formed by repeated carry-reduction steps, one per cycle, each step preserving the two's-complement total, until the carry word is zero.
- R4: When the sum exceeds the mantissa range, the block shifts the result right once and raises the exponent field by one.
- R5: Raising the exponent field from 127 sets ovf and wraps the field to 0. Otherwise, ovf is cleared when a start is accepted.
- R6: With norm_en set, the block shifts the result left one bit per cycle and lowers the exponent field by one per shift. It stops once res_man[40] differs from res_man[39] or the field reaches 0. A zero mantissa therefore ends with field 0. With norm_en clear, no left shift occurs.
- R7: With equal exponents, a zero operand mantissa after sign conditioning, and norm_en clear, done is high after the 5th rising edge, counting the edge that samples start.
- R8: Adding zero mantissas with exponent fields 127 and 0 with norm_en set raises done after the 259th edge, counting the same way.
- R9: done is a one-cycle pulse. busy is high from the edge that samples start through the done cycle. A start while busy is ignored and leaves the running result unchanged.
- R10: After reset, busy, done and ovf are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| opcode | input | 2 | Operation select, see R1 |
| norm_en | input | 1 | Enable left normalization |
| acc_exp | input | 7 | Accumulator exponent field |
| acc_man | input | 41 | Accumulator mantissa |
| op_exp | input | 7 | Operand exponent field |
| op_man | input | 41 | Operand mantissa |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_exp | output | 7 | Result exponent field |
| res_man | output | 41 | Result upper mantissa (new accumulator) |
| res_ext | output | 40 | Result lower mantissa bits |
| ovf | output | 1 | Exponent overflow flag |

## Verification
The assertions assume that start is the only input that matters once an operation is running. Opcode, norm_en and the operands are captured at the accepted start and are not looked at again. The phase assertions also rely on reset completing before the first start. The directed tasks hold every input steady from the start pulse until done. The one deliberate exception is a start pulse, with different operands, injected in the middle of a long run.

// File: rtl/seq_fp_adder_pkg.sv
package seq_fp_adder_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ALIGN, ST_REDUCE, ST_FIX, ST_NORM, ST_DONE
  } phase_t;

  typedef enum logic [1:0] {
    OPC_ADD  = 2'b00,
    OPC_SUB  = 2'b01,
    OPC_RSUB = 2'b10,
    OPC_ABSD = 2'b11
  } opc_t;
endpackage

// File: rtl/fpa_condition.sv
module fpa_condition #(
  parameter int FRAC_W = 40,
  localparam int MAN_W  = FRAC_W + 1,
  localparam int WORK_W = 2 * FRAC_W + 2
) (
  input  logic [MAN_W-1:0]  man,
  input  logic              take_abs,
  input  logic              negate,
  output logic [WORK_W-1:0] wide
);
  logic [MAN_W:0] ext;
  logic [MAN_W:0] mag;
  logic [MAN_W:0] fin;

  always_comb begin
    ext = {man[MAN_W-1], man};
    mag = (take_abs && ext[MAN_W]) ? (~ext + 1'b1) : ext;
    fin = negate ? (~mag + 1'b1) : mag;
    wide = {fin, {FRAC_W{1'b0}}};
  end
endmodule

// File: rtl/fpa_carry_step.sv
module fpa_carry_step #(
  parameter int WORK_W = 82
) (
  input  logic [WORK_W-1:0] a,
  input  logic [WORK_W-1:0] b,
  output logic [WORK_W-1:0] s,
  output logic [WORK_W-1:0] c
);
  assign c[0] = 1'b0;
  for (genvar i = 0; i < WORK_W; i++) begin : g_bit
    assign s[i] = a[i] ^ b[i];
    if (i < WORK_W - 1) begin : g_cy
      assign c[i+1] = a[i] & b[i];
    end
  end
endmodule

// File: rtl/seq_fp_adder.sv
module seq_fp_adder
  import seq_fp_adder_pkg::*;
#(
  parameter int EXP_W  = 7,
  parameter int FRAC_W = 40,
  localparam int MAN_W  = FRAC_W + 1,
  localparam int WORK_W = 2 * FRAC_W + 2,
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        opcode,
  input  logic              norm_en,
  input  logic [EXP_W-1:0]  acc_exp,
  input  logic [MAN_W-1:0]  acc_man,
  input  logic [EXP_W-1:0]  op_exp,
  input  logic [MAN_W-1:0]  op_man,
  output logic              busy,
  output logic              done,
  output logic [EXP_W-1:0]  res_exp,
  output logic [MAN_W-1:0]  res_man,
  output logic [FRAC_W-1:0] res_ext,
  output logic              ovf
);
  phase_t             st_q, st_n;
  logic [WORK_W-1:0]  wa_q, wa_n, wb_q, wb_n;
  logic [EXP_W-1:0]   ea_q, ea_n, eb_q, eb_n;
  logic               nrm_q, nrm_n, ovf_q, ovf_n;

  logic               abs_both, neg_acc, neg_op;
  logic [WORK_W-1:0]  cond_acc, cond_op, red_s, red_c;

  always_comb begin
    abs_both = (opc_t'(opcode) == OPC_ABSD);
    neg_acc  = (opc_t'(opcode) == OPC_RSUB);
    neg_op   = (opc_t'(opcode) == OPC_SUB) || abs_both;
  end

  fpa_condition #(.FRAC_W(FRAC_W)) u_cond_acc (
    .man(acc_man), .take_abs(abs_both), .negate(neg_acc), .wide(cond_acc));
  fpa_condition #(.FRAC_W(FRAC_W)) u_cond_op (
    .man(op_man), .take_abs(abs_both), .negate(neg_op), .wide(cond_op));
  fpa_carry_step #(.WORK_W(WORK_W)) u_step (
    .a(wa_q), .b(wb_q), .s(red_s), .c(red_c));

  // next-state logic
  always_comb begin
    st_n  = st_q;
    wa_n  = wa_q;
    wb_n  = wb_q;
    ea_n  = ea_q;
    eb_n  = eb_q;
    nrm_n = nrm_q;
    ovf_n = ovf_q;
    case (st_q)
      ST_IDLE: if (start) begin
        wa_n  = cond_acc;
        wb_n  = cond_op;
        ea_n  = acc_exp;
        eb_n  = op_exp;
        nrm_n = norm_en;
        ovf_n = 1'b0;
        st_n  = ST_ALIGN;
      end
      ST_ALIGN: begin
        if (ea_q == eb_q) begin
          st_n = ST_REDUCE;
        end else if (ea_q < eb_q) begin
          wa_n = {wa_q[WORK_W-1], wa_q[WORK_W-1:1]};
          ea_n = ea_q + 1'b1;
        end else begin
          wb_n = {wb_q[WORK_W-1], wb_q[WORK_W-1:1]};
          eb_n = eb_q + 1'b1;
        end
      end
      ST_REDUCE: begin
        if (wb_q == '0) begin
          st_n = ST_FIX;
        end else begin
          wa_n = red_s;
          wb_n = red_c;
        end
      end
      ST_FIX: begin
        if (wa_q[WORK_W-1] != wa_q[WORK_W-2]) begin
          wa_n = {wa_q[WORK_W-1], wa_q[WORK_W-1:1]};
          ea_n = ea_q + 1'b1;
          if (ea_q == EXP_MAX) ovf_n = 1'b1;
        end
        st_n = ST_NORM;
      end
      ST_NORM: begin
        if (nrm_q && (wa_q[WORK_W-2] == wa_q[WORK_W-3]) && (ea_q != '0)) begin
          wa_n = {wa_q[WORK_W-2:0], 1'b0};
          ea_n = ea_q - 1'b1;
        end else begin
          st_n = ST_DONE;
        end
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  // registers with async reset; datapath held when idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      wa_q  <= '0;
      wb_q  <= '0;
      ea_q  <= '0;
      eb_q  <= '0;
      nrm_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      st_q <= st_n;
      if (st_q != ST_DONE) begin
        wa_q  <= wa_n;
        wb_q  <= wb_n;
        ea_q  <= ea_n;
        eb_q  <= eb_n;
        nrm_q <= nrm_n;
        ovf_q <= ovf_n;
      end
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = (st_q == ST_DONE);
  assign res_exp = ea_q;
  assign res_man = wa_q[WORK_W-2:FRAC_W];
  assign res_ext = wa_q[FRAC_W-1:0];
  assign ovf     = ovf_q;

  // ---------------- assertions ----------------
  logic [EXP_W-1:0]  align_gap;
  logic [WORK_W-1:0] pair_sum;
  assign align_gap = (ea_q > eb_q) ? (ea_q - eb_q) : (eb_q - ea_q);
  assign pair_sum  = wa_q + wb_q;

  // R2: each alignment cycle closes the exponent gap by exactly one
  assert_align_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ALIGN && ea_q != eb_q) |=>
      (st_q == ST_ALIGN && align_gap == $past(align_gap) - 1'b1));

  // R3: a reduction step never changes the total
  assert_reduce_keeps_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REDUCE && wb_q != '0) |=> (pair_sum == $past(pair_sum)));

  // R5: the flag only rises out of a correction at the top exponent
  assert_ovf_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($past(st_q) == ST_FIX && $past(ea_q) == EXP_MAX));

  // R6: a normalization shift lowers the exponent by one
  assert_norm_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NORM && $past(st_q) == ST_NORM) |-> (ea_q == $past(ea_q) - 1'b1));

  // R9: done lasts one cycle and busy only begins on a start
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/sim_seq_fp_adder.sv
`timescale 1ns/1ps
module sim_seq_fp_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opcode = 2'b00;
  logic        norm_en = 1'b0;
  logic [6:0]  acc_exp = '0, op_exp = '0;
  logic [40:0] acc_man = '0, op_man = '0;
  logic        busy, done, ovf;
  logic [6:0]  res_exp;
  logic [40:0] res_man;
  logic [39:0] res_ext;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  seq_fp_adder u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .norm_en(norm_en),
    .acc_exp(acc_exp), .acc_man(acc_man), .op_exp(op_exp), .op_man(op_man),
    .busy(busy), .done(done), .res_exp(res_exp), .res_man(res_man),
    .res_ext(res_ext), .ovf(ovf));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, got %0d cycles, expected < 150000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model from the requirements: signed values, scaled by 2^80
  function automatic logic signed [81:0] scaled(input logic [40:0] m, input bit ab, input bit ng);
    logic signed [41:0] v;
    v = signed'({m[40], m});
    if (ab && v < 0) v = -v;
    if (ng) v = -v;
    return {v, 40'b0};
  endfunction

  task automatic model(input logic [1:0] opc, input bit nrm,
                       input logic [6:0] ea, input logic [40:0] ma,
                       input logic [6:0] eb, input logic [40:0] mb,
                       output logic [6:0] e, output logic [80:0] m, output bit o);
    logic signed [81:0] a, b, s;
    a = scaled(ma, opc == 2'b11, opc == 2'b10);
    b = scaled(mb, opc == 2'b11, opc == 2'b01 || opc == 2'b11);
    if (ea < eb) begin a = a >>> (eb - ea); e = eb; end
    else begin b = b >>> (ea - eb); e = ea; end
    s = a + b;
    o = 1'b0;
    if (s[81] != s[80]) begin
      s = s >>> 1;
      if (e == 7'd127) o = 1'b1;
      e = e + 7'd1;
    end
    if (nrm)
      while (s[80] == s[79] && e != 7'd0) begin
        s = s <<< 1;
        e = e - 7'd1;
      end
    m = s[80:0];
  endtask

  // Drive an operation, return edges from the start-sampling edge to done
  task automatic launch(input logic [1:0] opc, input bit nrm,
                        input logic [6:0] ea, input logic [40:0] ma,
                        input logic [6:0] eb, input logic [40:0] mb,
                        input int poke_at, output int lat);
    @(negedge clk);
    opcode = opc; norm_en = nrm; acc_exp = ea; acc_man = ma; op_exp = eb; op_man = mb;
    start = 1'b1;
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
      if (poke_at != 0 && lat == poke_at) begin
        acc_man = 41'h0FF_0000_0000; op_man = 41'h0AA_0000_0000;
        acc_exp = 7'd64; op_exp = 7'd64; opcode = 2'b01; start = 1'b1;
      end
      if (done) break;
      if (lat > 1000) break;
    end
    start = 1'b0;
  endtask

  task automatic run_case(input string req, input logic [1:0] opc, input bit nrm,
                          input logic [6:0] ea, input logic [40:0] ma,
                          input logic [6:0] eb, input logic [40:0] mb,
                          input int want_lat);
    int lat;
    logic [6:0] e; logic [80:0] m; bit o;
    model(opc, nrm, ea, ma, eb, mb, e, m, o);
    launch(opc, nrm, ea, ma, eb, mb, 0, lat);
    check({req, " mantissa"}, {47'b0, res_man, res_ext}, {47'b0, m});
    check({req, " exponent"}, 128'(res_exp), 128'(e));
    check({req, " ovf"}, 128'(ovf), 128'(o));
    if (want_lat > 0) check({req, " latency"}, 128'(lat), 128'(want_lat));
  endtask

  task automatic t_reset();
    check("R10 busy", 128'(busy), 128'(0));
    check("R10 done", 128'(done), 128'(0));
    check("R10 ovf", 128'(ovf), 128'(0));
  endtask

  task automatic t_opcodes();  // R1: all four opcodes, with and without norm
    run_case("R1 add", 2'b00, 1'b0, 7'd64, 41'h030_0000_0000, 7'd64, 41'h010_0000_0000, 0);
    run_case("R1 sub", 2'b01, 1'b0, 7'd64, 41'h030_0000_0000, 7'd64, 41'h050_0000_0000, 0);
    run_case("R1 rsub", 2'b10, 1'b1, 7'd70, 41'h030_0000_0000, 7'd70, 41'h050_0000_0001, 0);
    run_case("R1 absd", 2'b11, 1'b1, 7'd64, 41'h1C0_0000_0000, 7'd64, 41'h020_0000_0003, 0);
  endtask

  task automatic t_align();  // R2: unequal exponents and sign fill
    run_case("R2 align", 2'b00, 1'b0, 7'd60, 41'h0C0_0000_0005, 7'd64, 41'h040_0000_0000, 0);
    run_case("R2 fill", 2'b00, 1'b0, 7'd127, 41'h000_0000_0000, 7'd0, 41'h100_0000_0000, 0);
    run_case("R2 fill norm", 2'b00, 1'b1, 7'd127, 41'h000_0000_0000, 7'd0, 41'h100_0000_0000, 0);
  endtask

  task automatic t_carry();  // R3: long carry chains, integer use
    run_case("R3 chain", 2'b00, 1'b0, 7'd64, 41'h1FF_FFFF_FFFF, 7'd64, 41'h000_0000_0001, 0);
    run_case("R3 mixed", 2'b01, 1'b0, 7'd64, 41'h000_0000_1234, 7'd64, 41'h0AB_CDEF_0123, 0);
  endtask

  task automatic t_overflow();  // R4 mantissa overflow, R5 exponent overflow
    run_case("R4 mant ovf", 2'b00, 1'b0, 7'd64, 41'h0C0_0000_0000, 7'd64, 41'h0C0_0000_0000, 0);
    run_case("R4 neg ovf", 2'b00, 1'b1, 7'd10, 41'h100_0000_0000, 7'd10, 41'h100_0000_0000, 0);
    run_case("R5 exp ovf", 2'b00, 1'b0, 7'd127, 41'h0C0_0000_0000, 7'd127, 41'h0C0_0000_0000, 0);
    run_case("R5 clear", 2'b00, 1'b0, 7'd64, 41'h010_0000_0000, 7'd64, 41'h010_0000_0000, 0);
  endtask

  task automatic t_norm();  // R6: small result shifted up, and disabled
    run_case("R6 norm on", 2'b01, 1'b1, 7'd64, 41'h040_0000_0001, 7'd64, 41'h040_0000_0000, 0);
    run_case("R6 norm off", 2'b01, 1'b0, 7'd64, 41'h040_0000_0001, 7'd64, 41'h040_0000_0000, 0);
    run_case("R6 floor", 2'b00, 1'b1, 7'd3, 41'h000_0000_0010, 7'd3, 41'h000_0000_0000, 0);
  endtask

  task automatic t_latency();  // R7 minimum, R8 worst case
    run_case("R7 min", 2'b00, 1'b0, 7'd64, 41'h000_0000_0005, 7'd64, 41'h000_0000_0000, 5);
    run_case("R8 zeros", 2'b00, 1'b1, 7'd0, 41'h000_0000_0000, 7'd127, 41'h000_0000_0000, 259);
  endtask

  task automatic t_handshake();  // R9: busy/done and start while busy
    int lat;
    logic [6:0] e; logic [80:0] m; bit o;
    model(2'b00, 1'b1, 7'd0, 41'h0A0_0000_0000, 7'd40, 41'h050_0000_0000, e, m, o);
    launch(2'b00, 1'b1, 7'd0, 41'h0A0_0000_0000, 7'd40, 41'h050_0000_0000, 10, lat);
    check("R9 busy at done", 128'(busy), 128'(1));
    check("R9 ignored start mantissa", {47'b0, res_man, res_ext}, {47'b0, m});
    check("R9 ignored start exponent", 128'(res_exp), 128'(e));
    @(negedge clk);
    check("R9 done pulse", 128'(done), 128'(0));
    check("R9 busy drop", 128'(busy), 128'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_opcodes();
    t_align();
    t_carry();
    t_overflow();
    t_norm();
    t_latency();
    t_handshake();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule